// File: doc/BRIEF.md
# Multi-partition flash command interpreter

This block decodes the command bus of a flash-style memory divided into equal partitions. Each write cycle carries an address and a data word. The low byte of the data word is taken as a command code. The upper address bits pick a partition, and the lower bits pick a word inside it. For every partition the block keeps a read mode: array, status or identifier. A read cycle returns whatever that mode selects.

Two-cycle commands are supported, in the usual setup then confirm pattern. A setup cycle moves its partition into status mode. Reads may arrive between the two writes, but a write that does not complete the sequence cancels it and raises an error. Block erase runs on a fixed busy count that stands in for the real cell operation, and at the end the block holds all ones. Word program completes in a single cycle. The array sits in a simple dual-port memory so that it maps onto block RAM.

Top module: `pflash_cmd`

## Requirements
- R1: After reset every partition is in array mode, the status byte is 80h (bit 7 ready = 1, bit 5 erase error = 0, bit 4 program error = 0, other bits 0), and no erase is running. Reset leaves array contents untouched.
- R2: The top log2(N_PART) address bits select the partition and the rest select the word. A read asserted in one cycle gives `rdata` and `rd_valid` = 1 in the next cycle. With no read, `rd_valid` is 0.
- R3: Command FFh puts the addressed partition in array mode. Command 70h puts it in status mode, where a read returns the status byte zero-extended on the low 8 data bits.
- R4: Setup code 20h puts the addressed partition in status mode. Between setup and confirm, a read of that partition returns status, while a read of another partition in array mode returns its array word.
- R5: Confirm code D0h right after 20h starts an erase of the block (BLK_WORDS aligned words) holding the confirm address and puts that partition in status mode. The ready bit reads 0 for ERASE_CYCLES cycles. Afterwards every word of the block reads FFFFh, and other blocks keep their data.
- R6: Any write other than D0h after 20h sets status bits 5 and 4 and cancels the sequence. That write has no other effect, so a following D0h starts nothing.
- R7: Code 40h puts the partition in status mode. The next write, whatever its value, stores its full data word at its own address.
- R8: Error bits stay set until code 50h or reset clears them. Other commands, FFh among them, leave them set.
- R9: Code 90h selects identifier mode. Word offset 0 reads 005Ah, offset 1 reads 00C3h, and any other offset reads 0000h.
- R10: A code outside {FFh, 70h, 90h, 50h, 20h, 40h} written with no sequence pending changes no mode, no status bit and no array word. A lone D0h also counts as such a code.
- R11: While an erase runs, codes 20h and 40h are ignored, and a read of the erasing partition returns status whatever its mode. Reads of the other partitions proceed normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write cycle strobe |
| rd_en | input | 1 | Read cycle strobe |
| addr | input | ADDR_W (6) | Partition bits above word offset bits |
| wdata | input | DATA_W (16) | Write data; low byte is the command code |
| rdata | output | DATA_W (16) | Read data, valid one cycle after `rd_en` |
| rd_valid | output | 1 | Marks the cycle `rdata` is valid |

## Verification
The assertions assume that read and write strobes are never high in the same cycle. They also assume that a command is judged only from the low data byte, and that the address is stable while a strobe is high. The bench drives a single strobe per cycle from tasks that raise it at a falling edge and drop it one cycle later, so these assumptions always hold. The erase length is checked with a counter in the checker against ERASE_CYCLES rather than by a fixed delay. Reads that occur during an erase target only partitions whose mode the bench has itself just set.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_STATUS = 2'd1,
    MODE_IDENT  = 2'd2
  } rd_mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ERASE = 2'd1,
    SEQ_PROG  = 2'd2
  } seq_e;

  localparam logic [7:0] CODE_ARRAY   = 8'hFF;
  localparam logic [7:0] CODE_STATUS  = 8'h70;
  localparam logic [7:0] CODE_IDENT   = 8'h90;
  localparam logic [7:0] CODE_CLEAR   = 8'h50;
  localparam logic [7:0] CODE_ERASE   = 8'h20;
  localparam logic [7:0] CODE_PROG    = 8'h40;
  localparam logic [7:0] CODE_CONFIRM = 8'hD0;

  localparam int SR_READY    = 7;
  localparam int SR_ERASE_ER = 5;
  localparam int SR_PROG_ER  = 4;

  localparam logic [7:0] ID_MAKER  = 8'h5A;
  localparam logic [7:0] ID_DEVICE = 8'hC3;

  typedef struct packed {
    logic     set_mode;
    rd_mode_e mode;
    logic     arm_erase;
    logic     arm_prog;
    logic     start_erase;
    logic     do_prog;
    logic     seq_err;
    logic     clr_err;
  } cmd_act_t;

endpackage

// File: rtl/pflash_decode.sv
module pflash_decode
  import pflash_pkg::*;
(
  input  logic       wr_en,
  input  logic [7:0] code,
  input  seq_e       seq,
  input  logic       busy,
  output cmd_act_t   act
);

  always_comb begin
    act      = '0;
    act.mode = MODE_ARRAY;
    if (wr_en) begin
      case (seq)
        SEQ_PROG: act.do_prog = 1'b1;
        SEQ_ERASE: begin
          if (code == CODE_CONFIRM) begin
            act.start_erase = 1'b1;
            act.set_mode    = 1'b1;
            act.mode        = MODE_STATUS;
          end else begin
            act.seq_err = 1'b1;
          end
        end
        default: begin
          case (code)
            CODE_ARRAY: begin
              act.set_mode = 1'b1;
              act.mode     = MODE_ARRAY;
            end
            CODE_STATUS: begin
              act.set_mode = 1'b1;
              act.mode     = MODE_STATUS;
            end
            CODE_IDENT: begin
              act.set_mode = 1'b1;
              act.mode     = MODE_IDENT;
            end
            CODE_CLEAR: act.clr_err = 1'b1;
            CODE_ERASE: begin
              if (!busy) begin
                act.arm_erase = 1'b1;
                act.set_mode  = 1'b1;
                act.mode      = MODE_STATUS;
              end
            end
            CODE_PROG: begin
              if (!busy) begin
                act.arm_prog = 1'b1;
                act.set_mode = 1'b1;
                act.mode     = MODE_STATUS;
              end
            end
            default: ;
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/pflash_modes.sv
module pflash_modes
  import pflash_pkg::*;
#(
  parameter int N_PART = 4,
  parameter int PART_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   set_en,
  input  logic [PART_W-1:0]      part,
  input  rd_mode_e               new_mode,
  output logic [N_PART-1:0][1:0] mode_q
);

  logic [N_PART-1:0] hit;

  for (genvar p = 0; p < N_PART; p++) begin : g_hit
    assign hit[p] = set_en && (part == PART_W'(p));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_PART; i++) begin
      if (rst)         mode_q[i] <= MODE_ARRAY;
      else if (hit[i]) mode_q[i] <= new_mode;
    end
  end

endmodule

// File: rtl/pflash_eraser.sv
module pflash_eraser #(
  parameter int ADDR_W       = 6,
  parameter int BLK_WORDS    = 4,
  parameter int ERASE_CYCLES = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [ADDR_W-BLK_W-1:0]  blk_addr,
  output logic                     busy,
  output logic                     we,
  output logic [ADDR_W-1:0]        waddr
);

  localparam int BLK_W = $clog2(BLK_WORDS);
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);

  logic [CNT_W-1:0]         cnt;
  logic [ADDR_W-BLK_W-1:0]  blk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      blk_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt   <= '0;
      blk_q <= blk_addr;
    end else if (busy) begin
      if (cnt == CNT_W'(ERASE_CYCLES - 1)) busy <= 1'b0;
      cnt <= cnt + 1'b1;
    end
  end

  assign we    = busy && (cnt < CNT_W'(BLK_WORDS));
  assign waddr = {blk_q, cnt[BLK_W-1:0]};

endmodule

// File: rtl/pflash_ram.sv
module pflash_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata_q
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_q <= mem[raddr];
  end

endmodule

// File: rtl/pflash_cmd.sv
module pflash_cmd
  import pflash_pkg::*;
#(
  parameter int N_PART       = 4,
  parameter int PART_WORDS   = 16,
  parameter int BLK_WORDS    = 4,
  parameter int DATA_W       = 16,
  parameter int ERASE_CYCLES = 12,
  localparam int ADDR_W      = $clog2(N_PART) + $clog2(PART_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid
);

  localparam int PART_W = $clog2(N_PART);
  localparam int OFF_W  = $clog2(PART_WORDS);
  localparam int BLK_W  = $clog2(BLK_WORDS);

  logic [PART_W-1:0] part;
  logic [OFF_W-1:0]  off;
  assign part = addr[ADDR_W-1:OFF_W];
  assign off  = addr[OFF_W-1:0];

  cmd_act_t act;
  seq_e     seq_q;
  logic     er_busy, er_we;
  logic [ADDR_W-1:0] er_waddr;
  logic [N_PART-1:0][1:0] mode_q;
  logic     err_erase_q, err_prog_q;
  logic [7:0] status_byte;

  pflash_decode u_dec (
    .wr_en (wr_en),
    .code  (wdata[7:0]),
    .seq   (seq_q),
    .busy  (er_busy),
    .act   (act)
  );

  pflash_modes #(.N_PART(N_PART), .PART_W(PART_W)) u_modes (
    .clk      (clk),
    .rst      (rst),
    .set_en   (act.set_mode),
    .part     (part),
    .new_mode (act.mode),
    .mode_q   (mode_q)
  );

  pflash_eraser #(.ADDR_W(ADDR_W), .BLK_WORDS(BLK_WORDS), .ERASE_CYCLES(ERASE_CYCLES)) u_eraser (
    .clk      (clk),
    .rst      (rst),
    .start    (act.start_erase),
    .blk_addr (addr[ADDR_W-1:BLK_W]),
    .busy     (er_busy),
    .we       (er_we),
    .waddr    (er_waddr)
  );

  // Sequence tracker: any write while a sequence is pending ends it.
  always_ff @(posedge clk) begin
    if (rst)                seq_q <= SEQ_IDLE;
    else if (act.arm_erase) seq_q <= SEQ_ERASE;
    else if (act.arm_prog)  seq_q <= SEQ_PROG;
    else if (wr_en)         seq_q <= SEQ_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_erase_q <= 1'b0;
      err_prog_q  <= 1'b0;
    end else if (act.seq_err) begin
      err_erase_q <= 1'b1;
      err_prog_q  <= 1'b1;
    end else if (act.clr_err) begin
      err_erase_q <= 1'b0;
      err_prog_q  <= 1'b0;
    end
  end

  always_comb begin
    status_byte              = '0;
    status_byte[SR_READY]    = !er_busy;
    status_byte[SR_ERASE_ER] = err_erase_q;
    status_byte[SR_PROG_ER]  = err_prog_q;
  end

  // Array: erase writes win; a program cannot be armed during an erase.
  logic              ram_we;
  logic [ADDR_W-1:0] ram_waddr;
  logic [DATA_W-1:0] ram_wdata, ram_q;

  assign ram_we    = er_we || act.do_prog;
  assign ram_waddr = er_we ? er_waddr : addr;
  assign ram_wdata = er_we ? {DATA_W{1'b1}} : wdata;

  pflash_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk     (clk),
    .we      (ram_we),
    .waddr   (ram_waddr),
    .wdata   (ram_wdata),
    .raddr   (addr),
    .rdata_q (ram_q)
  );

  // Read path
  rd_mode_e          eff_mode;
  logic              sel_arr_q;
  logic [DATA_W-1:0] aux_q;

  always_comb begin
    if (er_busy && (er_waddr[ADDR_W-1:OFF_W] == part)) eff_mode = MODE_STATUS;
    else                                               eff_mode = rd_mode_e'(mode_q[part]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      sel_arr_q <= 1'b0;
      aux_q     <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        sel_arr_q <= (eff_mode == MODE_ARRAY);
        case (eff_mode)
          MODE_STATUS: aux_q <= DATA_W'(status_byte);
          MODE_IDENT: begin
            if (off == OFF_W'(0))      aux_q <= DATA_W'(ID_MAKER);
            else if (off == OFF_W'(1)) aux_q <= DATA_W'(ID_DEVICE);
            else                       aux_q <= '0;
          end
          default: aux_q <= '0;
        endcase
      end
    end
  end

  assign rdata = sel_arr_q ? ram_q : aux_q;

endmodule

// File: rtl/pflash_cmd_chk.sv
module pflash_cmd_chk
  import pflash_pkg::*;
#(
  parameter int N_PART       = 4,
  parameter int ERASE_CYCLES = 12
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic                   rd_en,
  input logic [$clog2(N_PART)-1:0] wr_part,
  input logic [7:0]             code,
  input logic                   rd_valid,
  input logic [7:0]             status,
  input logic                   busy,
  input seq_e                   seq,
  input logic [N_PART-1:0][1:0] modes
);

  localparam int PART_W = $clog2(N_PART);
  localparam int RUN_W  = $clog2(ERASE_CYCLES + 2);

  logic [PART_W-1:0] last_part;
  logic [RUN_W-1:0]  busy_run;
  logic              known_code;

  always_ff @(posedge clk) begin
    last_part <= wr_part;
    if (rst || !busy) busy_run <= '0;
    else              busy_run <= busy_run + 1'b1;
  end

  assign known_code = (code == CODE_ARRAY) || (code == CODE_STATUS) ||
                      (code == CODE_IDENT) || (code == CODE_CLEAR)  ||
                      (code == CODE_ERASE) || (code == CODE_PROG);

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (status == 8'h80 && modes == '0 && !busy));

  p_rd_valid_r2: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  p_no_valid_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  p_setup_status_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && seq == SEQ_IDLE && !busy && code == CODE_ERASE)
      |=> (modes[last_part] == MODE_STATUS && seq == SEQ_ERASE));

  p_confirm_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && seq == SEQ_ERASE && code == CODE_CONFIRM) |=> !status[SR_READY]);

  p_busy_len_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (busy_run < RUN_W'(ERASE_CYCLES)));

  p_seq_error_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && seq == SEQ_ERASE && code != CODE_CONFIRM)
      |=> (status[SR_ERASE_ER] && status[SR_PROG_ER] && seq == SEQ_IDLE));

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (status[SR_ERASE_ER] && !(wr_en && seq == SEQ_IDLE && code == CODE_CLEAR))
      |=> status[SR_ERASE_ER]);

  p_reserved_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && seq == SEQ_IDLE && !known_code) |=> ($stable(modes) && $stable(status[5:4])));

  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en && seq == SEQ_IDLE && (code == CODE_ERASE || code == CODE_PROG))
      |=> seq == SEQ_IDLE);

endmodule

bind pflash_cmd pflash_cmd_chk #(.N_PART(N_PART), .ERASE_CYCLES(ERASE_CYCLES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .wr_part  (addr[ADDR_W-1:OFF_W]),
  .code     (wdata[7:0]),
  .rd_valid (rd_valid),
  .status   (status_byte),
  .busy     (er_busy),
  .seq      (seq_q),
  .modes    (mode_q)
);

// File: tb/pflash_cmd_test.sv
module pflash_cmd_test;

  localparam int CLK_PERIOD = 10;
  localparam int ERASE_CYC  = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rd_valid;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pflash_cmd #(.ERASE_CYCLES(ERASE_CYC)) uut (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .rd_valid (rd_valid)
  );

  function automatic logic [5:0] loc(input int p, input int w);
    return {p[1:0], w[3:0]};
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
    chk("R2 rd_valid", {15'd0, rd_valid}, 16'd1);
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic t_program;
    wr(loc(1, 3), 16'h0040); wr(loc(1, 3), 16'h1234);
    rd_chk("R7 status after program", loc(1, 3), 16'h0080);
    wr(loc(2, 3), 16'h0040); wr(loc(2, 3), 16'h2323);
    wr(loc(2, 5), 16'h0040); wr(loc(2, 5), 16'hBEEF);
    wr(loc(0, 1), 16'h0040); wr(loc(0, 1), 16'h1111);
    wr(loc(0, 4), 16'h0040); wr(loc(0, 4), 16'h4444);
    wr(loc(1, 0), 16'h00FF);
    rd_chk("R7 R3 programmed word", loc(1, 3), 16'h1234);
    wr(loc(2, 0), 16'h00FF);
    rd_chk("R2 same offset other partition", loc(2, 3), 16'h2323);
    @(negedge clk);
    chk("R2 rd_valid idle", {15'd0, rd_valid}, 16'd0);
  endtask

  task automatic t_reset;
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd_chk("R1 array mode after reset", loc(0, 1), 16'h1111);
    wr(loc(3, 0), 16'h0070);
    rd_chk("R1 R3 status after reset", loc(3, 0), 16'h0080);
  endtask

  task automatic t_erase;
    wr(loc(0, 0), 16'h0020);
    rd_chk("R4 other partition array", loc(1, 3), 16'h1234);
    rd_chk("R4 setup partition status", loc(0, 2), 16'h0080);
    wr(loc(0, 2), 16'h00D0);
    rd_chk("R5 busy ready low", loc(0, 0), 16'h0000);
    rd_chk("R11 other partition during erase", loc(2, 5), 16'hBEEF);
    wr(loc(0, 0), 16'h00FF);
    rd_chk("R11 busy partition forced status", loc(0, 1), 16'h0000);
    wr(loc(2, 5), 16'h0040);
    rd_chk("R11 program setup ignored", loc(2, 5), 16'hBEEF);
    repeat (ERASE_CYC + 2) @(negedge clk);
    wr(loc(0, 0), 16'h0070);
    rd_chk("R5 ready after erase", loc(0, 0), 16'h0080);
    wr(loc(0, 0), 16'h00FF);
    rd_chk("R5 erased word", loc(0, 1), 16'hFFFF);
    rd_chk("R5 erased word end", loc(0, 3), 16'hFFFF);
    rd_chk("R5 other block kept", loc(0, 4), 16'h4444);
  endtask

  task automatic t_seq_error;
    wr(loc(3, 0), 16'h0020);
    wr(loc(0, 4), 16'h0020);
    wr(loc(0, 4), 16'h00D0);
    rd_chk("R6 sequence error bits", loc(3, 0), 16'h00B0);
    rd_chk("R6 no erase started", loc(0, 4), 16'h4444);
  endtask

  task automatic t_sticky;
    wr(loc(3, 0), 16'h00FF);
    wr(loc(3, 0), 16'h0070);
    rd_chk("R8 errors survive FFh", loc(3, 0), 16'h00B0);
    wr(loc(3, 0), 16'h0050);
    rd_chk("R8 clear status", loc(3, 0), 16'h0080);
  endtask

  task automatic t_ident;
    wr(loc(1, 0), 16'h0090);
    rd_chk("R9 maker code", loc(1, 0), 16'h005A);
    rd_chk("R9 device code", loc(1, 1), 16'h00C3);
    rd_chk("R9 other offset", loc(1, 2), 16'h0000);
  endtask

  task automatic t_reserved;
    wr(loc(2, 5), 16'h0033);
    rd_chk("R10 array untouched", loc(2, 5), 16'hBEEF);
    wr(loc(1, 0), 16'h00D0);
    rd_chk("R10 ident mode kept", loc(1, 0), 16'h005A);
    wr(loc(2, 0), 16'h0070);
    rd_chk("R10 no error flagged", loc(2, 0), 16'h0080);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_program();
    t_reset();
    t_erase();
    t_seq_error();
    t_sticky();
    t_ident();
    t_reserved();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule